// File: doc/BRIEF.md
# Multi-rate Clock Enable Generator

This block turns a single fast base clock into the one-cycle enable strobes that pace a small microcontroller subsystem: the processor core, the timer/counters, the serial peripheral interface unit, the analog-to-digital converter and the watchdog. Nothing downstream gets a clock of its own. Every unit runs on the base clock and acts only in the cycles where its enable is high.

The processor, timer and serial strobes are spaced according to two mode inputs: a bus speed select (full or low) and a rate-doubling select that is active low. These strobes hang off a 12 MHz timeline made of periods of `NOM_TICKS` base ticks. A recovery unit upstream can ask for one period to be shortened (advance) or lengthened (retard) by one base tick, and the 24 MHz and 1.5 MHz strobes move with the timeline. The converter and watchdog strobes come from a separate divider that phase correction never touches.

With the default parameters the base clock is 48 MHz. A nominal 12 MHz period is then 4 ticks, the 1.5 MHz rate is every 8th period, and the fixed 1 MHz rate is every 48 ticks.

Top module: `rate_enable_gen`

## Requirements
- R1: While `rstN` is low every enable output is 0. After release, the first 12 MHz strobe and the first fixed-rate strobe appear together on the `NOM_TICKS`-th rising edge (edge 4 by default). The first 24 MHz strobe comes on edge 2.
- R2: With `lowSpeed`=0 and `dblClkN`=1, `enCpu` and `enTmr` pulse once per 12 MHz period. That is every 4 ticks when no correction is applied.
- R3: With `dblClkN`=0, at either speed, `enCpu` pulses twice per 12 MHz period and `enTmr` once. `enTmr` is high only in cycles where `enCpu` is high.
- R4: With `lowSpeed`=1 and `dblClkN`=1, `enCpu` and `enTmr` pulse only on every `SLOW_DIV`-th 12 MHz period end. By default that is every 32 ticks.
- R5: `enAdc` and `enWdt` pulse together every `FIX_DIV` ticks (48 by default) in every mode, whatever phase corrections are applied.
- R6: `enSpi` equals `enCpu` in every cycle.
- R7: A `phaseAdv` pulse makes the next 12 MHz period `NOM_TICKS`-1 ticks long. A `phaseRet` pulse makes it `NOM_TICKS`+1 ticks long. When both are high in the same cycle, the advance wins.
- R8: At most one correction is applied per period. A request sampled on the edge that ends a period, or at any time during a period, is held and applied to the following period. A later request in the same period replaces an earlier one.
- R9: The mode inputs are sampled on the first edge after reset and then only on 1.5 MHz boundaries. A boundary is every `SLOW_DIV`-th period end, and the first period end counts as one. The strobe produced at a boundary still follows the old mode.
- R10: Within every 12 MHz period, the mid-period 24 MHz strobe comes 2 ticks after the previous period end, so any correction falls in the second half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock (48 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| lowSpeed | input | 1 | Bus speed select: 1 = low speed, 0 = full speed |
| dblClkN | input | 1 | Rate-doubling select, active low |
| phaseAdv | input | 1 | Request to shorten the next 12 MHz period by one tick |
| phaseRet | input | 1 | Request to lengthen the next 12 MHz period by one tick |
| enCpu | output | 1 | Processor enable strobe |
| enTmr | output | 1 | Timer/counter enable strobe |
| enSpi | output | 1 | Serial peripheral interface enable strobe |
| enAdc | output | 1 | Converter enable strobe (fixed rate) |
| enWdt | output | 1 | Watchdog enable strobe (fixed rate) |

## Verification
The bench builds the block with `NOM_TICKS`=4, `SLOW_DIV`=4 and `FIX_DIV`=20. The smaller slow divider brings many 1.5 MHz boundaries into a short run, so mode changes land both just before and just after a boundary. The smaller fixed divider makes the independent strobe cross adjusted 3-tick and 5-tick periods many times. The reference model tracks the strobe times as absolute tick numbers. Back-to-back advances, retards during an adjusted period, and simultaneous requests are all compared against it on every edge.

// File: rtl/rate_enable_pkg.sv
package rate_enable_pkg;

  // Timeline strobes from the control to the datapath.
  typedef struct packed {
    logic tick12;    // end of a 12 MHz period
    logic tick24;    // end of a period or its midpoint
    logic tickSlow;  // 1.5 MHz boundary (a period end)
  } paceStrobes_t;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_ADV  = 2'd1,
    ADJ_RET  = 2'd2
  } adjReq_t;

endpackage

// File: rtl/rate_timeline_ctrl.sv
module rate_timeline_ctrl
  import rate_enable_pkg::*;
#(
  parameter int NOM_TICKS = 4,
  parameter int SLOW_DIV  = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advReq,
  input  logic         retReq,
  output paceStrobes_t pace
);

  localparam int PH_W = $clog2(NOM_TICKS + 2);
  localparam int SL_W = $clog2(SLOW_DIV);
  localparam int MID  = NOM_TICKS / 2 - 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] lastPh;
  logic [SL_W-1:0] slowCnt;
  adjReq_t         pend;
  adjReq_t         effReq;
  logic            periodEnd;

  // Newest request wins; advance beats retard in the same cycle.
  always_comb begin
    if (advReq)      effReq = ADJ_ADV;
    else if (retReq) effReq = ADJ_RET;
    else             effReq = pend;
  end

  assign periodEnd = (phase == lastPh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      lastPh  <= PH_W'(NOM_TICKS - 1);
      pend    <= ADJ_NONE;
      slowCnt <= SL_W'(SLOW_DIV - 1);
    end else if (periodEnd) begin
      phase <= '0;
      case (effReq)
        ADJ_ADV: lastPh <= PH_W'(NOM_TICKS - 2);
        ADJ_RET: lastPh <= PH_W'(NOM_TICKS);
        default: lastPh <= PH_W'(NOM_TICKS - 1);
      endcase
      pend    <= ADJ_NONE;
      slowCnt <= (slowCnt == SL_W'(SLOW_DIV - 1)) ? '0 : slowCnt + 1'b1;
    end else begin
      phase <= phase + 1'b1;
      pend  <= effReq;
    end
  end

  always_comb begin
    pace.tick12   = periodEnd;
    pace.tick24   = periodEnd || (phase == PH_W'(MID));
    pace.tickSlow = periodEnd && (slowCnt == SL_W'(SLOW_DIV - 1));
  end

  // Checker: spacing between consecutive period ends.
  logic [PH_W:0] sinceEnd;
  logic          seenEnd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceEnd <= '0;
      seenEnd  <= 1'b0;
    end else if (pace.tick12) begin
      sinceEnd <= '0;
      seenEnd  <= 1'b1;
    end else begin
      sinceEnd <= sinceEnd + 1'b1;
    end
  end

  AST_PERIOD_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (pace.tick12 && seenEnd) |-> (sinceEnd >= (PH_W+1)'(NOM_TICKS - 2) &&
                                  sinceEnd <= (PH_W+1)'(NOM_TICKS))); // R7

  AST_MID_BEFORE_END: assert property (@(posedge clk) disable iff (!rstN)
    (pace.tick24 && !pace.tick12 && seenEnd) |-> (sinceEnd == (PH_W+1)'(MID))); // R10

endmodule

// File: rtl/rate_enable_dp.sv
module rate_enable_dp
  import rate_enable_pkg::*;
#(
  parameter int NOM_TICKS = 4,
  parameter int FIX_DIV   = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  paceStrobes_t pace,
  input  logic         lowSpeed,
  input  logic         dblClkN,
  output logic         enCpu,
  output logic         enTmr,
  output logic         enSpi,
  output logic         enAdc,
  output logic         enWdt
);

  localparam int FX_W = $clog2(FIX_DIV);
  localparam int GP_W = $clog2(FIX_DIV + 1);

  logic            modeLs;
  logic            modeDblN;
  logic            firstQ;
  logic [FX_W-1:0] fixCnt;
  logic            fixEnd;
  logic            cpuNext;
  logic            tmrNext;

  assign fixEnd = (fixCnt == FX_W'(FIX_DIV - 1));

  // Rate matrix selected by the held mode.
  always_comb begin
    if (!modeDblN) begin
      cpuNext = pace.tick24;
      tmrNext = pace.tick12;
    end else if (!modeLs) begin
      cpuNext = pace.tick12;
      tmrNext = pace.tick12;
    end else begin
      cpuNext = pace.tickSlow;
      tmrNext = pace.tickSlow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeLs   <= 1'b0;
      modeDblN <= 1'b0;
      firstQ   <= 1'b1;
      fixCnt   <= FX_W'(FIX_DIV - NOM_TICKS);
      enCpu    <= 1'b0;
      enTmr    <= 1'b0;
      enSpi    <= 1'b0;
      enAdc    <= 1'b0;
      enWdt    <= 1'b0;
    end else begin
      firstQ <= 1'b0;
      if (firstQ || pace.tickSlow) begin
        modeLs   <= lowSpeed;
        modeDblN <= dblClkN;
      end
      fixCnt <= fixEnd ? '0 : fixCnt + 1'b1;
      enCpu  <= cpuNext;
      enSpi  <= cpuNext;
      enTmr  <= tmrNext;
      enAdc  <= fixEnd;
      enWdt  <= fixEnd;
    end
  end

  // Checker: spacing of the fixed-rate strobe.
  logic [GP_W-1:0] fixGap;
  logic            seenFix;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fixGap  <= '0;
      seenFix <= 1'b0;
    end else if (enAdc) begin
      fixGap  <= '0;
      seenFix <= 1'b1;
    end else begin
      fixGap <= fixGap + 1'b1;
    end
  end

  AST_FIX_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (enAdc && seenFix) |-> (fixGap == GP_W'(FIX_DIV - 1))); // R5

  AST_TMR_WITH_CPU: assert property (@(posedge clk) disable iff (!rstN)
    enTmr |-> enCpu); // R3

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!firstQ && !pace.tickSlow) |=> $stable({modeLs, modeDblN})); // R9

endmodule

// File: rtl/rate_enable_gen.sv
module rate_enable_gen
  import rate_enable_pkg::*;
#(
  parameter int NOM_TICKS = 4,
  parameter int SLOW_DIV  = 8,
  parameter int FIX_DIV   = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowSpeed,
  input  logic dblClkN,
  input  logic phaseAdv,
  input  logic phaseRet,
  output logic enCpu,
  output logic enTmr,
  output logic enSpi,
  output logic enAdc,
  output logic enWdt
);

  paceStrobes_t pace;

  rate_timeline_ctrl #(
    .NOM_TICKS(NOM_TICKS),
    .SLOW_DIV (SLOW_DIV)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .advReq(phaseAdv),
    .retReq(phaseRet),
    .pace  (pace)
  );

  rate_enable_dp #(
    .NOM_TICKS(NOM_TICKS),
    .FIX_DIV  (FIX_DIV)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .pace    (pace),
    .lowSpeed(lowSpeed),
    .dblClkN (dblClkN),
    .enCpu   (enCpu),
    .enTmr   (enTmr),
    .enSpi   (enSpi),
    .enAdc   (enAdc),
    .enWdt   (enWdt)
  );

endmodule

// File: tb/rate_enable_gen_tb.sv
module rate_enable_gen_tb_top;

  localparam int NOM  = 4;
  localparam int SLOW = 4;
  localparam int FIX  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowSpeed = 1'b0;
  logic dblClkN = 1'b1;
  logic phaseAdv = 1'b0;
  logic phaseRet = 1'b0;
  logic enCpu, enTmr, enSpi, enAdc, enWdt;

  always #5 clk = ~clk;

  rate_enable_gen #(.NOM_TICKS(NOM), .SLOW_DIV(SLOW), .FIX_DIV(FIX)) dut_i (
    .clk(clk), .rstN(rstN), .lowSpeed(lowSpeed), .dblClkN(dblClkN),
    .phaseAdv(phaseAdv), .phaseRet(phaseRet),
    .enCpu(enCpu), .enTmr(enTmr), .enSpi(enSpi), .enAdc(enAdc), .enWdt(enWdt)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string curTag = "R1";

  // Reference model: strobe times as absolute edge numbers since release.
  int n, tStart, tEnd, nPer, fixNext, pend;
  bit mLs, mDbl;

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s at edge %0d: actual=%0b expected=%0b", tag, what, n, act, exp);
    end
  endtask

  task automatic modelReset();
    n = 0; tStart = 0; tEnd = NOM; nPer = 0; fixNext = NOM; pend = 0;
    mLs = 1'b0; mDbl = 1'b0;
  endtask

  task automatic step(input bit adv, input bit ret);
    bit e12, e24, bnd, eFix, xCpu, xTmr;
    phaseAdv = adv;
    phaseRet = ret;
    @(posedge clk);
    #2;
    n++;
    if (adv) pend = 1; else if (ret) pend = 2;
    e12  = (n == tEnd);
    e24  = e12 || (n == tStart + 2);
    bnd  = e12 && (nPer % SLOW == 0);
    eFix = (n == fixNext);
    if (!mDbl) begin xCpu = e24; xTmr = e12; end
    else if (!mLs) begin xCpu = e12; xTmr = e12; end
    else begin xCpu = bnd; xTmr = bnd; end
    chk(enCpu, xCpu, curTag, "enCpu");
    chk(enTmr, xTmr, curTag, "enTmr");
    chk(enSpi, xCpu, "R6", "enSpi");
    chk(enAdc, eFix, "R5", "enAdc");
    chk(enWdt, eFix, "R5", "enWdt");
    if (n == 1 || bnd) begin mLs = lowSpeed; mDbl = dblClkN; end
    if (e12) begin
      nPer++;
      tStart = n;
      tEnd = n + ((pend == 1) ? NOM - 1 : (pend == 2) ? NOM + 1 : NOM);
      pend = 0;
    end
    if (eFix) fixNext += FIX;
    @(negedge clk);
  endtask

  task automatic run(input int cnt);
    for (int i = 0; i < cnt; i++) step(1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: outputs low throughout reset
    repeat (3) begin
      @(posedge clk); #2;
      checks++;
      if ({enCpu, enTmr, enSpi, enAdc, enWdt} !== 5'b0) begin
        failures++;
        $display("FAIL R1 reset outputs actual=%b expected=00000",
                 {enCpu, enTmr, enSpi, enAdc, enWdt});
      end
    end
    @(negedge clk);
    modelReset();
    rstN = 1'b1;
    curTag = "R1"; run(6);
    curTag = "R2"; run(40);
    // R9: mode change lands at the next boundary
    dblClkN = 1'b0; curTag = "R9"; run(3);
    lowSpeed = 1'b1; run(37);
    curTag = "R3"; run(30);
    lowSpeed = 1'b0; run(30);
    curTag = "R4"; lowSpeed = 1'b1; dblClkN = 1'b1; run(110);
    curTag = "R9"; dblClkN = 1'b0; run(5); dblClkN = 1'b1; run(40);
    lowSpeed = 1'b0; dblClkN = 1'b0; run(40);
    // R7: single advance, single retard, simultaneous requests
    curTag = "R7";
    step(1'b1, 1'b0); run(12);
    step(1'b0, 1'b1); run(12);
    step(1'b1, 1'b1); run(12);
    // R8: requests held, replaced, and repeated every cycle
    curTag = "R8";
    step(1'b1, 1'b0); step(1'b0, 1'b1); run(10);
    step(1'b0, 1'b1); step(1'b0, 1'b0); step(1'b1, 1'b0); run(10);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    run(8);
    // R10: midpoint placement under retards
    curTag = "R10";
    for (int i = 0; i < 40; i++) step(1'b0, (i % 7) == 0);
    // R5: fixed strobes across corrections in slow mode
    curTag = "R5";
    lowSpeed = 1'b1; dblClkN = 1'b1;
    for (int i = 0; i < 80; i++) step((i % 5) == 0, (i % 9) == 0);
    curTag = "R2"; lowSpeed = 1'b0; run(50);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule